// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Block

This block sits beside one processor core and gathers interrupt requests that other cores post to it. Software reaches it through a simple 32-bit register port: an access strobe, a write flag, an address, write data and registered read data. Pending requests live in a status word. That word changes only through two write-only ports, one that sets bits and one that clears bits. An enable mask decides which pending bits may raise the single level-sensitive interrupt line.

A bank of 32-bit mailbox words lets cores pass small payloads to each other. A write to the send-command offset is not stored. Its data goes out on a one-cycle strobe to an external sender, which delivers it to the target core. Any access to an offset the block does not decode, or a write to the read-only status word, pulses an error flag.

Top module: `ipi_core_regs`

## Requirements
- R1: After reset, status, enable, every mailbox word and the interrupt output are all zero.
- R2: Only address bits [7:0] are decoded. An address whose higher bits differ reaches the same register.
- R3: The status word at offset 0x00 reads back the pending bits. A write to it leaves status unchanged and pulses the error flag for one cycle.
- R4: A write to offset 0x08 ORs the write data into status. The interrupt is raised when the resulting status ANDed with enable is nonzero. Otherwise the interrupt level is left as it was.
- R5: A write to offset 0x0C clears the status bits that are one in the write data. The interrupt is lowered only when the resulting status is zero and enable is nonzero. Otherwise the interrupt level is left as it was.
- R6: A write to offset 0x04 replaces the whole enable mask, and a read of 0x04 returns it. A write to enable never changes the interrupt output by itself.
- R7: Reads of offsets 0x08 and 0x0C always return zero and raise no error.
- R8: Mailbox word k sits at offset 0x20 + 4*k for k = 0..MBOX_WORDS-1 (0x20 to 0x3C by default). Each word keeps the last 32-bit value written to it and returns that value on a read.
- R9: A write to offset 0x40 pulses send_stb for one cycle, one cycle after the access, with send_data equal to the write data. Nothing in the block is stored.
- R10: An access to any other offset has no effect on state and pulses the error flag for one cycle. Such offsets include mailbox offsets whose low two bits are nonzero, and reads of 0x40. A read of such an offset returns zero.
- R11: Each read returns its data on rd_data with rd_valid high in the cycle after the access. Writes do not raise rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | BUS_AW | Access address; only bits [7:0] are decoded |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read data valid, one cycle after a read access |
| acc_err | output | 1 | One-cycle pulse for an illegal or undecoded access |
| irq | output | 1 | Level interrupt to the core |
| send_stb | output | 1 | One-cycle strobe carrying a send command |
| send_data | output | 32 | Send command data |

## Verification
The assertions assume that every access lasts exactly one cycle and that acc_we and acc_addr are stable whenever acc_en is high. They also assume that reset is held for at least one clock edge before the first access. The stimulus uses a single task to issue accesses. That task raises acc_en for one cycle between falling edges and then drops it, so no two accesses overlap. The stimulus covers the corner where a clear leaves status zero while enable is zero, and checks that the interrupt stays high in that case. It also covers a clear that leaves status nonzero.

// File: rtl/ipi_regs_pkg.sv
package ipi_regs_pkg;
  localparam int DW = 32;
  localparam int DEC_W = 8;

  localparam logic [DEC_W-1:0] OFF_STATUS = 8'h00;
  localparam logic [DEC_W-1:0] OFF_ENABLE = 8'h04;
  localparam logic [DEC_W-1:0] OFF_SET    = 8'h08;
  localparam logic [DEC_W-1:0] OFF_CLEAR  = 8'h0C;
  localparam logic [DEC_W-1:0] OFF_MBOX   = 8'h20;
  localparam logic [DEC_W-1:0] OFF_SEND   = 8'h40;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_SET,
    SEL_CLEAR,
    SEL_MBOX,
    SEL_SEND
  } reg_sel_e;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_regs_pkg::*;
#(
  parameter int BUS_AW     = 16,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic              we,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  mbox_idx
);
  localparam int MBOX_SPAN = 4 * MBOX_WORDS;

  logic [DEC_W-1:0] off;
  logic [DEC_W:0]   rel;

  assign off = addr[DEC_W-1:0];
  assign rel = {1'b0, off} - {1'b0, OFF_MBOX};
  assign mbox_idx = rel[IDX_W+1:2];

  always_comb begin
    sel = SEL_NONE;
    if (off == OFF_STATUS)      sel = SEL_STATUS;
    else if (off == OFF_ENABLE) sel = SEL_ENABLE;
    else if (off == OFF_SET)    sel = SEL_SET;
    else if (off == OFF_CLEAR)  sel = SEL_CLEAR;
    else if (off == OFF_SEND && we) sel = SEL_SEND;
    else if (off >= OFF_MBOX && int'(rel) < MBOX_SPAN && off[1:0] == 2'b00)
      sel = SEL_MBOX;
  end
endmodule

// File: rtl/ipi_status_ctrl.sv
module ipi_status_ctrl
  import ipi_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_mask,
  input  logic          wr_set,
  input  logic          wr_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status,
  output logic [DW-1:0] enable,
  output logic          irq
);
  logic [DW-1:0] status_set;
  logic [DW-1:0] status_clr;

  assign status_set = status | wdata;
  assign status_clr = status & ~wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en_mask) enable <= wdata;
      if (wr_set) begin
        status <= status_set;
        if ((status_set & enable) != '0) irq <= 1'b1;
      end else if (wr_clr) begin
        status <= status_clr;
        if (status_clr == '0 && enable != '0) irq <= 1'b0;
      end
    end
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    (wr_set && ((status | wdata) & enable) != '0) |=> irq); // R4
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && (status & ~wdata) == '0 && enable != '0) |=> !irq); // R5
  AST_ENABLE_KEEPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en_mask && !wr_set && !wr_clr) |=> irq == $past(irq)); // R6
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_set && !wr_clr) |=> $stable(status)); // R3
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_regs_pkg::*;
#(
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [MBOX_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MBOX_WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[idx];
  end

  AST_MBOX_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(idx)] == $past(wdata)); // R8
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_regs_pkg::*;
#(
  parameter int BUS_AW     = 16,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [BUS_AW-1:0] acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              acc_err,
  output logic              irq,
  output logic              send_stb,
  output logic [DW-1:0]     send_data
);
  reg_sel_e         sel;
  logic [IDX_W-1:0] mbox_idx;
  logic [DW-1:0]    status, enable, mbox_rd;
  logic             wr;
  logic [DW-1:0]    scalar_rd;
  logic [DW-1:0]    scalar_q;
  logic             from_mbox_q;
  logic             bad;

  assign wr = acc_en && acc_we;

  ipi_addr_decode #(.BUS_AW(BUS_AW), .MBOX_WORDS(MBOX_WORDS)) u_dec (
    .addr(acc_addr), .we(acc_we), .sel(sel), .mbox_idx(mbox_idx)
  );

  ipi_status_ctrl u_stat (
    .clk(clk), .rst(rst),
    .wr_en_mask(wr && sel == SEL_ENABLE),
    .wr_set(wr && sel == SEL_SET),
    .wr_clr(wr && sel == SEL_CLEAR),
    .wdata(acc_wdata),
    .status(status), .enable(enable), .irq(irq)
  );

  ipi_mailbox #(.MBOX_WORDS(MBOX_WORDS)) u_mbox (
    .clk(clk), .rst(rst),
    .we(wr && sel == SEL_MBOX),
    .idx(mbox_idx), .wdata(acc_wdata), .rdata(mbox_rd)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: scalar_rd = status;
      SEL_ENABLE: scalar_rd = enable;
      default:    scalar_rd = '0;
    endcase
  end

  assign bad = (sel == SEL_NONE) || (acc_we && sel == SEL_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      scalar_q    <= '0;
      from_mbox_q <= 1'b0;
      rd_valid    <= 1'b0;
      acc_err     <= 1'b0;
      send_stb    <= 1'b0;
      send_data   <= '0;
    end else begin
      rd_valid    <= acc_en && !acc_we;
      acc_err     <= acc_en && bad;
      send_stb    <= wr && sel == SEL_SEND;
      from_mbox_q <= sel == SEL_MBOX;
      scalar_q    <= scalar_rd;
      if (wr && sel == SEL_SEND) send_data <= acc_wdata;
    end
  end

  assign rd_data = from_mbox_q ? mbox_rd : scalar_q;

  AST_SEND_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_SEND) |=> (send_stb && send_data == $past(acc_wdata))); // R9
  AST_SEND_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(acc_en && acc_we) |=> !send_stb); // R9
  AST_BAD_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (acc_en && sel == SEL_NONE) |=> acc_err); // R10
  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_we) |=> rd_valid); // R11
endmodule

// File: tb/ipi_core_regs_tb.sv
module ipi_core_regs_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_en = 1'b0, acc_we = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [31:0]   acc_wdata = '0;
  logic [31:0]   rd_data, send_data;
  logic          rd_valid, acc_err, irq, send_stb;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ipi_core_regs #(.BUS_AW(AW), .MBOX_WORDS(8)) u_dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .acc_err(acc_err), .irq(irq),
    .send_stb(send_stb), .send_data(send_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected rd_valid", 32'd1, 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  // one access: called and returns at a falling edge; outputs are then updated
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [31:0] d);
    acc_en = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    access(1'b1, a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    access(1'b0, a, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(16'h0000, 32'h0, "R1 status after reset");
    rd(16'h0004, 32'h0, "R1 enable after reset");
    rd(16'h0020, 32'h0, "R1 mailbox0 after reset");
    rd(16'h003C, 32'h0, "R1 mailbox7 after reset");

    wr(16'h0004, 32'h0000_00F0);
    chk("R11 no rd_valid on write", {31'd0, rd_valid}, 32'd0);
    rd(16'h0004, 32'h0000_00F0, "R6 enable readback");
    wr(16'h0008, 32'h0000_0003);
    chk("R4 set outside enable keeps irq low", {31'd0, irq}, 32'd0);
    rd(16'h0000, 32'h0000_0003, "R4 status after set");
    wr(16'h0008, 32'h0000_0010);
    chk("R4 set inside enable raises irq", {31'd0, irq}, 32'd1);

    wr(16'h0000, 32'hFFFF_FFFF);
    chk("R3 status write flags error", {31'd0, acc_err}, 32'd1);
    @(negedge clk);
    chk("R3 error is one cycle", {31'd0, acc_err}, 32'd0);
    rd(16'h0000, 32'h0000_0013, "R3 status unchanged by write");

    wr(16'h0004, 32'h0);
    chk("R6 enable write keeps irq", {31'd0, irq}, 32'd1);
    wr(16'h000C, 32'h0000_0010);
    chk("R5 partial clear keeps irq", {31'd0, irq}, 32'd1);
    wr(16'h000C, 32'h0000_0003);
    chk("R5 clear to zero with enable zero keeps irq", {31'd0, irq}, 32'd1);
    rd(16'h0000, 32'h0, "R5 status cleared");
    wr(16'h0004, 32'h0000_0001);
    chk("R6 enable write keeps irq high", {31'd0, irq}, 32'd1);
    wr(16'h000C, 32'h0);
    chk("R5 zero status with enable drops irq", {31'd0, irq}, 32'd0);

    wr(16'h0008, 32'h0000_0006);
    chk("R4 set outside enable leaves irq low", {31'd0, irq}, 32'd0);
    wr(16'h0008, 32'h0000_0001);
    chk("R4 set raises irq", {31'd0, irq}, 32'd1);
    wr(16'h000C, 32'h0000_0001);
    chk("R5 nonzero status keeps irq", {31'd0, irq}, 32'd1);
    wr(16'h000C, 32'h0000_0006);
    chk("R5 full clear drops irq", {31'd0, irq}, 32'd0);

    rd(16'h0008, 32'h0, "R7 set offset reads zero");
    chk("R7 no error on set read", {31'd0, acc_err}, 32'd0);
    rd(16'h000C, 32'h0, "R7 clear offset reads zero");

    for (int i = 0; i < 8; i++) wr(16'h0020 + 16'(4*i), 32'hA500_0000 | 32'(i * 17));
    for (int i = 0; i < 8; i++) rd(16'h0020 + 16'(4*i), 32'hA500_0000 | 32'(i * 17), "R8 mailbox readback");

    wr(16'h1F24, 32'h1234_5678);
    rd(16'h0024, 32'h1234_5678, "R2 high address bits ignored on write");
    rd(16'hAB04, 32'h0000_0001, "R2 high address bits ignored on read");

    wr(16'h0040, 32'hCAFE_F00D);
    chk("R9 send strobe", {31'd0, send_stb}, 32'd1);
    chk("R9 send data", send_data, 32'hCAFE_F00D);
    @(negedge clk);
    chk("R9 strobe one cycle", {31'd0, send_stb}, 32'd0);
    rd(16'h003C, 32'hA500_0077, "R9 send stores nothing");
    rd(16'h0000, 32'h0, "R9 status untouched by send");

    wr(16'h0080, 32'hFFFF_FFFF);
    chk("R10 undecoded write flags error", {31'd0, acc_err}, 32'd1);
    rd(16'h0080, 32'h0, "R10 undecoded read zero");
    chk("R10 undecoded read flags error", {31'd0, acc_err}, 32'd1);
    wr(16'h0022, 32'h5555_5555);
    chk("R10 unaligned mailbox offset flags error", {31'd0, acc_err}, 32'd1);
    rd(16'h0020, 32'hA500_0000, "R10 unaligned write leaves mailbox");
    rd(16'h0040, 32'h0, "R10 send offset read zero");
    chk("R10 send read flags error", {31'd0, acc_err}, 32'd1);
    rd(16'h0004, 32'h0000_0001, "R10 enable unchanged");
    chk("R10 irq unchanged", {31'd0, irq}, 32'd0);

    repeat (2) @(negedge clk);
    chk("R11 all reads returned", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule